// File: doc/BRIEF.md
# I2C Master Controller

This block is an I2C bus master that works through a queue of command entries. Software, or any producer, hands it entries over a valid/ready stream. Each entry holds one data byte and two flags: one asks for a (repeated) START before the byte, and one asks for a STOP after it. The block moves the entries through a small FIFO. It serialises each byte MSB first on open-drain SCL and SDA outputs and samples both lines back through synchronisers.

A small register port gives access to three registers. The status register holds four sticky event flags plus the live bus state. The control register enables each flag as an interrupt source. The divider register sets the length of each SCL phase. If the queue runs dry in the middle of a transaction, the master keeps SCL low and raises a data-request flag, and it resumes when the next entry arrives. If it loses arbitration, it lets go of both lines at once and throws away the rest of that transaction.

Stream rules: an entry is taken on a clock edge where `tx_valid` and `tx_ready` are both high. The producer must hold `tx_entry` steady while `tx_valid` is high and `tx_ready` is low. `tx_ready` depends only on FIFO occupancy and never on `tx_valid`. SDA only changes while SCL is low, except where a START or STOP is formed on purpose.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset, both line enables are low, `irq` is low, `tx_ready` is high, and status (address 0) reads 0x40 while the bus floats high.
- R2: An entry is `tx_entry[9]` = START request, `tx_entry[8]` = STOP request, `tx_entry[7:0]` = byte. The FIFO holds DEPTH entries, and `tx_ready` is low while DEPTH entries are waiting.
- R3: From idle, the master issues a START (even if bit 9 is clear) and sends each byte MSB first, with a ninth clock for the acknowledge. An acknowledged byte that carries STOP ends with a STOP condition and sets status bit 0. Writing 1 to status bit 0 clears it.
- R4: An entry taken in the middle of a transaction with bit 9 set is preceded by a repeated START, without a STOP in between.
- R5: A byte that is not acknowledged sets status bit 2. The master then issues a STOP and does not set bit 0. Bit 2 clears when an entry is accepted on the stream.
- R6: If the FIFO is empty after an acknowledged byte without STOP, the master holds SCL low and sets status bit 3 until an entry arrives. Accepting an entry clears bit 3, and the transfer goes on.
- R7: If the master releases SDA for a data bit and samples it low, it sets status bit 1, releases both lines in the same cycle, and drops the queued entries up to and including the next one with STOP. Writing 1 to status bit 1 clears it.
- R8: Status bit 5 sets on any START seen on the synchronised bus (SDA falling while SCL high) and clears on any STOP (SDA rising while SCL high).
- R9: Status bit 6 shows the synchronised SCL level.
- R10: Control register (address 1) bits 3:0 enable status bits 3:0. `irq` is high exactly when some enabled flag is set.
- R11: Divider (address 2) value D (values below 2 act as 2) gives each SCL phase at least D+1 cycles. A high phase is counted only once SCL is seen high, so a target that holds SCL low delays the master without corrupting data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Entry offered on the stream |
| tx_ready | output | 1 | FIFO can accept an entry |
| tx_entry | input | 10 | {start, stop, byte} |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 status, 1 control, 2 divider |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr` |
| scl_i | input | 1 | SCL level on the bus |
| sda_i | input | 1 | SDA level on the bus |
| scl_oe | output | 1 | Pull SCL low when high |
| sda_oe | output | 1 | Pull SDA low when high |
| irq | output | 1 | Combined interrupt |

## Verification
A model target on the open-drain bus logs every byte it clocks in, counts START and STOP conditions, and can acknowledge, refuse, hold SCL or pull SDA down. Random transactions of one to three entries, with random repeated STARTs, divider values and clock holds, check that the byte order and the framing survive any mix of entries. Directed cases cover each path on its own: a refused byte (STOP without done), a dry queue (SCL held with the request flag set), lost arbitration (lines released and the queue purged), and a full FIFO (back-pressure). Each of these leaves a different pattern in the flags and the bus counts.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;

  localparam int REG_W = 8;

  typedef struct packed {
    logic       start;
    logic       stop;
    logic [7:0] data;
  } tx_entry_t;

  localparam int ENTRY_W = $bits(tx_entry_t);

  // status bit positions
  localparam int ST_DONE = 0;
  localparam int ST_ARB  = 1;
  localparam int ST_NACK = 2;
  localparam int ST_DREQ = 3;
  localparam int ST_BUSY = 5;
  localparam int ST_SCL  = 6;

  localparam logic [1:0] A_STATUS = 2'd0;
  localparam logic [1:0] A_CTRL   = 2'd1;
  localparam logic [1:0] A_DIV    = 2'd2;

  typedef enum logic [3:0] {
    E_IDLE, E_ST_HOLD, E_BIT_LO, E_BIT_WAIT, E_BIT_HI, E_NEXT, E_STALL,
    E_SP_LO, E_SP_WAIT, E_SP_HI, E_SP_END, E_RS_LO, E_RS_WAIT, E_RS_HI,
    E_FLUSH
  } eng_state_t;

endpackage

// File: rtl/i2cm_fifo.sv
module i2cm_fifo #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [W-1:0]  in_data,
  input  logic          pop,
  output logic          out_valid,
  output logic [W-1:0]  out_data,
  output logic [CW-1:0] count
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          push, do_pop;

  assign in_ready  = (count != CW'(DEPTH));
  assign out_valid = (count != '0);
  assign out_data  = mem[rd_ptr];
  assign push      = in_valid && in_ready;
  assign do_pop    = pop && out_valid;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (push && wr_ptr == AW'(g)) mem[g] <= in_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= nxt(wr_ptr);
      if (do_pop) rd_ptr <= nxt(rd_ptr);
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/i2cm_busmon.sv
module i2cm_busmon (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic start_det,
  output logic stop_det
);

  logic [1:0] scl_ff, sda_ff;
  logic       sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff   <= 2'b11;
      sda_ff   <= 2'b11;
      sda_prev <= 1'b1;
    end else begin
      scl_ff   <= {scl_ff[0], scl_i};
      sda_ff   <= {sda_ff[0], sda_i};
      sda_prev <= sda_ff[1];
    end
  end

  assign scl_s     = scl_ff[1];
  assign sda_s     = sda_ff[1];
  assign start_det = scl_s &&  sda_prev && !sda_s;
  assign stop_det  = scl_s && !sda_prev &&  sda_s;

endmodule

// File: rtl/i2cm_engine.sv
module i2cm_engine
  import i2cm_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] div,
  input  logic             scl_s,
  input  logic             sda_s,
  input  logic             head_vld,
  input  tx_entry_t        head,
  output logic             pop,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             ev_done,
  output logic             ev_arb,
  output logic             ev_nack,
  output logic             ev_dreq
);

  localparam logic [DIV_W-1:0] DIV_MIN = DIV_W'(2);

  eng_state_t       st;
  logic [DIV_W-1:0] cnt, eff_div;
  logic [3:0]       bitcnt;
  logic [7:0]       shreg;
  logic             stop_pend, nack_seen, phase_end, lost;

  assign eff_div   = (div < DIV_MIN) ? DIV_MIN : div;
  assign phase_end = (cnt == eff_div);
  assign lost      = (st == E_BIT_HI) && phase_end && (bitcnt < 4'd8) && !sda_oe && !sda_s;

  assign pop = head_vld && ((st == E_IDLE) || (st == E_FLUSH) ||
                            (st == E_NEXT && !nack_seen && !stop_pend));

  assign ev_arb  = lost;
  assign ev_nack = (st == E_BIT_HI) && phase_end && (bitcnt == 4'd8) && sda_s;
  assign ev_dreq = (st == E_NEXT) && !nack_seen && !stop_pend && !head_vld;
  assign ev_done = (st == E_SP_END) && phase_end && !nack_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= E_IDLE;
      cnt       <= '0;
      bitcnt    <= '0;
      shreg     <= '0;
      stop_pend <= 1'b0;
      nack_seen <= 1'b0;
      scl_oe    <= 1'b0;
      sda_oe    <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
      case (st)
        E_IDLE: begin
          cnt <= '0;
          if (head_vld) begin
            shreg     <= head.data;
            stop_pend <= head.stop;
            nack_seen <= 1'b0;
            sda_oe    <= 1'b1;
            st        <= E_ST_HOLD;
          end
        end
        E_ST_HOLD: if (phase_end) begin
          scl_oe <= 1'b1;
          cnt    <= '0;
          bitcnt <= '0;
          st     <= E_BIT_LO;
        end
        E_BIT_LO: begin
          if (cnt == '0) sda_oe <= (bitcnt < 4'd8) ? ~shreg[7] : 1'b0;
          if (phase_end) begin
            scl_oe <= 1'b0;
            st     <= E_BIT_WAIT;
          end
        end
        E_BIT_WAIT: begin
          cnt <= '0;
          if (scl_s) st <= E_BIT_HI;
        end
        E_BIT_HI: if (phase_end) begin
          cnt <= '0;
          if (lost) begin
            scl_oe <= 1'b0;
            sda_oe <= 1'b0;
            st     <= stop_pend ? E_IDLE : E_FLUSH;
          end else begin
            scl_oe <= 1'b1;
            if (bitcnt == 4'd8) begin
              if (sda_s) nack_seen <= 1'b1;
              st <= E_NEXT;
            end else begin
              shreg  <= {shreg[6:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
              st     <= E_BIT_LO;
            end
          end
        end
        E_NEXT: begin
          cnt <= '0;
          if (nack_seen || stop_pend) begin
            sda_oe <= 1'b1;
            st     <= E_SP_LO;
          end else if (head_vld) begin
            shreg     <= head.data;
            stop_pend <= head.stop;
            bitcnt    <= '0;
            if (head.start) begin
              sda_oe <= 1'b0;
              st     <= E_RS_LO;
            end else begin
              st <= E_BIT_LO;
            end
          end else begin
            st <= E_STALL;
          end
        end
        E_STALL: begin
          cnt <= '0;
          if (head_vld) st <= E_NEXT;
        end
        E_SP_LO: if (phase_end) begin
          scl_oe <= 1'b0;
          st     <= E_SP_WAIT;
        end
        E_SP_WAIT: begin
          cnt <= '0;
          if (scl_s) st <= E_SP_HI;
        end
        E_SP_HI: if (phase_end) begin
          sda_oe <= 1'b0;
          cnt    <= '0;
          st     <= E_SP_END;
        end
        E_SP_END: if (phase_end) st <= E_IDLE;
        E_RS_LO: if (phase_end) begin
          scl_oe <= 1'b0;
          st     <= E_RS_WAIT;
        end
        E_RS_WAIT: begin
          cnt <= '0;
          if (scl_s) st <= E_RS_HI;
        end
        E_RS_HI: if (phase_end) begin
          sda_oe <= 1'b1;
          cnt    <= '0;
          st     <= E_ST_HOLD;
        end
        E_FLUSH: begin
          if (!head_vld || head.stop) st <= E_IDLE;
        end
        default: st <= E_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
  import i2cm_pkg::*;
#(
  parameter int DEPTH       = 4,
  parameter int DIV_RESET   = 4,
  localparam int CW         = $clog2(DEPTH + 1),
  localparam int DIV_W      = REG_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_valid,
  output logic             tx_ready,
  input  logic [ENTRY_W-1:0] tx_entry,
  input  logic             reg_wr,
  input  logic [1:0]       reg_addr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             irq
);

  logic [ENTRY_W-1:0] head_raw;
  logic [CW-1:0]      fifo_cnt;
  logic               head_vld, pop, tx_fire;
  logic               scl_s, sda_s, start_det, stop_det;
  logic               ev_done, ev_arb, ev_nack, ev_dreq;
  logic [3:0]         flags_q, ien_q, ev_vec, clr_vec;
  logic               busy_q;
  logic [DIV_W-1:0]   div_q;
  logic               wr_status;

  assign tx_fire = tx_valid && tx_ready;

  i2cm_fifo #(.W(ENTRY_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .in_valid(tx_valid), .in_ready(tx_ready), .in_data(tx_entry),
    .pop(pop), .out_valid(head_vld), .out_data(head_raw), .count(fifo_cnt)
  );

  i2cm_busmon u_mon (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det)
  );

  i2cm_engine #(.DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_n), .div(div_q), .scl_s(scl_s), .sda_s(sda_s),
    .head_vld(head_vld), .head(tx_entry_t'(head_raw)), .pop(pop),
    .scl_oe(scl_oe), .sda_oe(sda_oe),
    .ev_done(ev_done), .ev_arb(ev_arb), .ev_nack(ev_nack), .ev_dreq(ev_dreq)
  );

  assign wr_status = reg_wr && (reg_addr == A_STATUS);

  assign ev_vec  = {ev_dreq, ev_nack, ev_arb, ev_done};
  assign clr_vec = {tx_fire, tx_fire,
                    wr_status && reg_wdata[ST_ARB],
                    wr_status && reg_wdata[ST_DONE]};

  // sticky flags: clear wins over a coincident event
  for (genvar g = 0; g < 4; g++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags_q[g] <= 1'b0;
      else if (clr_vec[g]) flags_q[g] <= 1'b0;
      else if (ev_vec[g])  flags_q[g] <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ien_q  <= '0;
      div_q  <= DIV_W'(DIV_RESET);
    end else begin
      if (start_det)     busy_q <= 1'b1;
      else if (stop_det) busy_q <= 1'b0;
      if (reg_wr && reg_addr == A_CTRL) ien_q <= reg_wdata[3:0];
      if (reg_wr && reg_addr == A_DIV)  div_q <= reg_wdata;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: begin
        reg_rdata[3:0]     = flags_q;
        reg_rdata[ST_BUSY] = busy_q;
        reg_rdata[ST_SCL]  = scl_s;
      end
      A_CTRL:  reg_rdata[3:0] = ien_q;
      A_DIV:   reg_rdata = div_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq = |(flags_q & ien_q);

endmodule

// File: rtl/i2cm_chk.sv
module i2cm_chk #(
  parameter int DEPTH = 4,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic          tx_fire,
  input logic          reg_wr,
  input logic [1:0]    reg_addr,
  input logic [7:0]    reg_wdata,
  input logic [3:0]    flags_q,
  input logic [CW-1:0] fifo_cnt,
  input logic          scl_oe,
  input logic          sda_oe,
  input logic          irq
);

  p_fifo_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CW'(DEPTH));

  p_backpressure_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (fifo_cnt <= $past(fifo_cnt)));

  p_done_w1c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == 2'd0 && reg_wdata[0]) |=> !flags_q[0]);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[0]) |-> (!scl_oe && !sda_oe));

  p_push_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_fire |=> (!flags_q[2] && !flags_q[3]));

  p_stall_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flags_q[3] |-> scl_oe);

  p_arb_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags_q[1]) |-> (!scl_oe && !sda_oe));

  p_irq_source_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (flags_q != 4'd0));

endmodule

bind i2cm_ctrl i2cm_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_fire(tx_fire), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .flags_q(flags_q), .fifo_cnt(fifo_cnt),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
);

// File: tb/i2cm_ctrl_tb.sv
module i2cm_ctrl_tb;

  localparam int DEPTH = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [9:0] tx_entry = '0;
  logic       reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic       scl_oe, sda_oe, irq;
  logic       scl_w, sda_w;

  // target model state
  logic ack_low = 1'b0, arb_low = 1'b0, hold_scl = 1'b0;
  logic ack_en = 1'b1, arb_mode = 1'b0, stretch_en = 1'b0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic [7:0] sh = '0;
  logic [7:0] log_q [0:63];
  int bitc = 0, hold_cnt = 0, log_n = 0, n_start = 0, n_stop = 0;
  int hi_cnt = 0, min_hi = 1000;

  int n_chk = 0, n_err = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign scl_w = !scl_oe && !hold_scl;
  assign sda_w = !sda_oe && !ack_low && !arb_low;

  i2cm_ctrl #(.DEPTH(DEPTH), .DIV_RESET(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_entry(tx_entry), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .scl_i(scl_w), .sda_i(sda_w),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .irq(irq)
  );

  always @(negedge clk) begin
    logic cs, cd;
    cs = scl_w;
    cd = sda_w;
    if (!arb_mode) arb_low = 1'b0;
    if (hold_cnt > 0) begin
      hold_cnt--;
      if (hold_cnt == 0) hold_scl = 1'b0;
    end
    if (cs) hi_cnt++;
    if (cs && p_sda && !cd) begin
      n_start++;
      bitc = 0;
      if (arb_mode) arb_low = 1'b1;
    end
    if (cs && !p_sda && cd) n_stop++;
    if (cs && !p_scl) begin
      if (bitc < 8) sh = {sh[6:0], cd};
      bitc++;
    end
    if (!cs && p_scl) begin
      if (hi_cnt < min_hi) min_hi = hi_cnt;
      if (bitc == 8) begin
        if (log_n < 64) log_q[log_n] = sh;
        log_n++;
        ack_low = ack_en;
      end else if (bitc == 9) begin
        ack_low = 1'b0;
        bitc = 0;
      end else if (bitc == 3 && stretch_en) begin
        hold_scl = 1'b1;
        hold_cnt = 30;
      end
    end
    if (!cs) hi_cnt = 0;
    p_scl = cs;
    p_sda = cd;
  end

  function automatic logic [7:0] exp_status(input logic done, arb, nack, dreq,
                                            busy, scl);
    return {1'b0, scl, busy, 1'b0, dreq, nack, arb, done};
  endfunction

  function automatic logic exp_irq(input logic [3:0] fl, input logic [3:0] en);
    return |(fl & en);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
      $finish;
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
    reg_addr = 2'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_addr = 2'd0; reg_wdata = '0;
  endtask

  task automatic push(input logic s, input logic p, input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_entry = {s, p, d};
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic wait_quiet(input string req);
    int q = 0, t = 0;
    while (q < 60 && t < 40000) begin
      @(negedge clk);
      t++;
      if (!scl_oe && !sda_oe && !hold_scl && !reg_rdata[5]) q++;
      else q = 0;
    end
    if (t >= 40000) chk({req, " bus idle timeout"}, 0, 1);
  endtask

  initial begin
    #(200000 * 4);
    n_err++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
  end

  initial begin
    logic [7:0] v;
    logic [7:0] exp_b [0:3];
    int base, st0, sp0, nb, nrs, t;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(2'd0, v);
    chk("R1 status", v, exp_status(0, 0, 0, 0, 0, 1));
    chk("R1 irq", irq, 0);
    chk("R1 line enables", {scl_oe, sda_oe}, 0);
    chk("R1 tx_ready", tx_ready, 1);

    // R3 plain write, R8 busy after
    base = log_n; sp0 = n_stop;
    push(1, 1, 8'hA5);
    wait_quiet("R3");
    chk("R3 byte", log_q[base], 8'hA5);
    chk("R3 stop seen", n_stop - sp0, 1);
    rd(2'd0, v);
    chk("R3 R8 status done, bus free", v, exp_status(1, 0, 0, 0, 0, 1));

    // R10 gating
    wr(2'd1, 8'h00);
    chk("R10 irq masked", irq, exp_irq(4'b0001, 4'b0000));
    wr(2'd1, 8'h01);
    chk("R10 irq enabled", irq, exp_irq(4'b0001, 4'b0001));
    wr(2'd0, 8'h01);
    rd(2'd0, v);
    chk("R3 done w1c", v, exp_status(0, 0, 0, 0, 0, 1));
    chk("R10 irq after clear", irq, 0);

    // R4 repeated start
    base = log_n; st0 = n_start; sp0 = n_stop;
    push(1, 0, 8'hA1);
    push(1, 1, 8'hB2);
    wait_quiet("R4");
    chk("R4 byte0", log_q[base], 8'hA1);
    chk("R4 byte1", log_q[base + 1], 8'hB2);
    chk("R4 starts", n_start - st0, 2);
    chk("R4 stops", n_stop - sp0, 1);
    wr(2'd0, 8'h01);

    // R5 nack
    ack_en = 1'b0; sp0 = n_stop;
    wr(2'd1, 8'h04);
    push(1, 1, 8'h77);
    wait_quiet("R5");
    rd(2'd0, v);
    chk("R5 nack no done", v, exp_status(0, 0, 1, 0, 0, 1));
    chk("R5 stop after nack", n_stop - sp0, 1);
    chk("R10 irq nack", irq, 1);
    ack_en = 1'b1;
    push(1, 1, 8'h12);
    rd(2'd0, v);
    chk("R5 push clears nack", v[2], 0);
    wait_quiet("R5b");
    wr(2'd0, 8'h01);

    // R6 starvation, R8/R9 live bits
    base = log_n;
    push(1, 0, 8'h5A);
    t = 0;
    v = '0;
    while (!v[3] && t < 3000) begin rd(2'd0, v); t++; end
    repeat (5) @(negedge clk);
    rd(2'd0, v);
    chk("R6 dreq set", v[3], 1);
    chk("R6 scl held", scl_oe, 1);
    chk("R8 busy mid transfer", v[5], 1);
    chk("R9 scl low seen", v[6], 0);
    push(0, 1, 8'h3C);
    rd(2'd0, v);
    chk("R6 push clears dreq", v[3], 0);
    wait_quiet("R6");
    chk("R6 byte0", log_q[base], 8'h5A);
    chk("R6 byte1", log_q[base + 1], 8'h3C);
    rd(2'd0, v);
    chk("R6 done after resume", v, exp_status(1, 0, 0, 0, 0, 1));
    wr(2'd0, 8'h01);

    // R7 arbitration loss
    arb_mode = 1'b1;
    base = log_n;
    push(1, 0, 8'hC3);
    push(0, 0, 8'h11);
    push(0, 1, 8'h22);
    t = 0; v = '0;
    while (!v[1] && t < 3000) begin rd(2'd0, v); t++; end
    chk("R7 arb flag", v[1], 1);
    chk("R7 lines released", {scl_oe, sda_oe}, 0);
    repeat (20) @(negedge clk);
    chk("R7 still released", {scl_oe, sda_oe}, 0);
    chk("R7 nothing logged", log_n - base, 0);
    arb_mode = 1'b0;
    wait_quiet("R7");
    wr(2'd0, 8'h02);
    rd(2'd0, v);
    chk("R7 arb w1c, R8 busy cleared", v, exp_status(0, 0, 0, 0, 0, 1));
    base = log_n;
    push(1, 1, 8'h99);
    wait_quiet("R7b");
    chk("R7 purged queue", log_n - base, 1);
    chk("R7 next byte", log_q[base], 8'h99);
    wr(2'd0, 8'h01);

    // R2 back-pressure
    wr(2'd2, 8'd20);
    base = log_n;
    push(1, 0, 8'h01);
    repeat (10) @(negedge clk);
    push(0, 0, 8'h02);
    push(0, 0, 8'h03);
    push(0, 0, 8'h04);
    push(0, 1, 8'h05);
    chk("R2 full not ready", tx_ready, 0);
    wait_quiet("R2");
    for (int i = 0; i < 5; i++) chk("R2 queued order", log_q[base + i], i + 1);
    wr(2'd0, 8'h01);

    // R11 divider and clock hold
    wr(2'd2, 8'd6);
    min_hi = 1000;
    stretch_en = 1'b1;
    base = log_n;
    push(1, 1, 8'h6E);
    wait_quiet("R11");
    stretch_en = 1'b0;
    chk("R11 byte with hold", log_q[base], 8'h6E);
    chk("R11 high phase >= div+1", (min_hi >= 7) ? 1 : 0, 1);
    wr(2'd0, 8'h01);

    // random transactions: R3 R4 R11
    for (int k = 0; k < 20; k++) begin
      wr(2'd2, 8'(2 + $urandom % 6));
      stretch_en = (($urandom % 4) == 0);
      nb = 1 + $urandom % 3;
      nrs = 0;
      base = log_n; st0 = n_start;
      for (int i = 0; i < nb; i++) begin
        logic rs;
        exp_b[i] = 8'($urandom);
        rs = (i > 0) && ($urandom % 2 == 1);
        if (rs) nrs++;
        push((i == 0) | rs, i == nb - 1, exp_b[i]);
      end
      wait_quiet("R3 random");
      stretch_en = 1'b0;
      for (int i = 0; i < nb; i++) chk("R3 random byte", log_q[base + i], exp_b[i]);
      chk("R4 random starts", n_start - st0, 1 + nrs);
      rd(2'd0, v);
      chk("R3 random done", v[0], 1);
      wr(2'd0, 8'h01);
    end

    summary();
  end

endmodule